// File: doc/BRIEF.md
# Polynomial Accumulate with Message Expansion

This block performs one closing pass of a lattice encryption step. Two 256-coefficient polynomials sit in two separate memory banks. The first is a partial sum and the second is a noise polynomial. For each coefficient position w, the block reads both banks in the same cycle and expands bit w of a 256-bit message into 0 or 1665. It adds the three terms and reduces the total modulo 3329. The result goes back into the partial-sum bank at the slot it came from.

Because each operand sits in its own bank, both reads share one cycle and neither bank sees two reads at once. The partial-sum bank needs one read port and one write port. The write for a coefficient is issued in the same cycle as its read data, so the result lands in the slot that was read and never one slot over. A host pulses `start` and waits for the one-cycle `done` pulse. It must keep `msg` stable while `busy` is high.

Top module: `poly_msg_acc`

## Requirements
- R1: After reset, `busy`, `done`, `a_re`, `b_re` and `a_we` are all 0 and stay 0 until `start` is seen.
- R2: Each written value equals (A[w] + B[w] + m(w)) mod 3329, where A and B are the bank contents at position w before the pass.
- R3: The message term m(w) is 1665 when `msg[w]` is 1 and 0 when it is 0. Bit w of `msg` belongs to coefficient w.
- R4: A write for position w is issued exactly one cycle after the read of position w, with `a_waddr` equal to that read address (in place, no slot skew).
- R5: Both banks are read in the same cycle at the same address.
- R6: One pass reads and writes positions 0 to 255 in ascending order, with exactly one write per position.
- R7: `done` is high for exactly one cycle, 257 clock edges after the edge that accepts `start`. `busy` is low in that cycle.
- R8: A `start` pulse while `busy` is high is ignored: the running pass neither restarts nor lengthens.
- R9: Every written value is below 3329 when the inputs are below 3329, including the largest case 3328 + 3328 + 1665.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass (ignored while busy) |
| msg | input | 256 | Message bits, bit w for coefficient w |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| a_re | output | 1 | Read enable, partial-sum bank |
| a_raddr | output | 8 | Read address, partial-sum bank |
| a_rdata | input | 12 | Read data, partial-sum bank (one-cycle latency) |
| a_we | output | 1 | Write enable, partial-sum bank |
| a_waddr | output | 8 | Write address, partial-sum bank |
| a_wdata | output | 12 | Write data (reduced sum) |
| b_re | output | 1 | Read enable, noise bank |
| b_raddr | output | 8 | Read address, noise bank |
| b_rdata | input | 12 | Read data, noise bank (one-cycle latency) |

## Verification
Take the edge that accepts `start` as edge 0. The read of position w is issued after edge w. Its result is written at edge w+2, and `done` is high in the cycle after edge 257. The bench drives and samples on falling edges. It counts falling edges from the accepting edge and expects `done` on the 257th. It logs every write at the bank model, then compares the write order, write count and final bank contents against a model computed from the inputs before the pass. A second `start` is injected in mid-pass, and the same 257-cycle count and 256-write log must result.

// File: rtl/poly_msg_acc_pkg.sv
// Shared constants for the polynomial accumulate pass.
// Assumes coefficients are stored reduced, below the modulus.
package poly_msg_acc_pkg;
    localparam int unsigned PMA_N  = 256;   // coefficients per polynomial
    localparam int unsigned PMA_CW = 12;    // coefficient width
    localparam int unsigned PMA_Q  = 3329;  // modulus
endpackage

// File: rtl/pma_seq.sv
// Pass sequencer: issues reads 0..N-1 and, one cycle later, the matching
// writes. Assumes a memory with one cycle of read latency.
// start is taken only when neither reads nor writes are outstanding.
module pma_seq #(
    parameter int unsigned N  = 256,
    parameter int unsigned AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          rd_en,
    output logic [AW-1:0] rd_idx,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic          busy,
    output logic          done
);
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    logic          issuing;
    logic [AW-1:0] rd_ptr;
    logic          pend;
    logic [AW-1:0] widx;
    logic          done_q;

    // Read issue, write scheduling aligned with read data, end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing <= 1'b0;
            rd_ptr  <= '0;
            pend    <= 1'b0;
            widx    <= '0;
            done_q  <= 1'b0;
        end else begin
            if (!busy && start) begin
                issuing <= 1'b1;
                rd_ptr  <= '0;
            end else if (issuing) begin
                if (rd_ptr == LAST) issuing <= 1'b0;
                else                rd_ptr  <= rd_ptr + 1'b1;
            end
            pend <= issuing;
            if (issuing) widx <= rd_ptr;
            done_q <= pend && (widx == LAST);
        end
    end

    assign rd_en  = issuing;
    assign rd_idx = rd_ptr;
    assign wr_en  = pend;
    assign wr_idx = widx;
    assign busy   = issuing | pend;
    assign done   = done_q;
endmodule

// File: rtl/pma_msg_term.sv
// One-bit message expansion: selects bit idx of the message and maps it to
// 0 or round(Q/2). Purely combinational.
module pma_msg_term #(
    parameter int unsigned N  = 256,
    parameter int unsigned AW = $clog2(N),
    parameter int unsigned CW = 12,
    parameter int unsigned Q  = 3329
) (
    input  logic [N-1:0]  msg,
    input  logic [AW-1:0] idx,
    output logic [CW-1:0] term
);
    localparam logic [CW-1:0] HALF_Q = CW'((Q + 1) / 2);

    // Bit select and expansion.
    always_comb term = msg[idx] ? HALF_Q : '0;
endmodule

// File: rtl/pma_modadd3.sv
// Three-operand modular adder. Assumes every operand is below Q, so the
// sum is below 3Q and two conditional subtractions fully reduce it.
module pma_modadd3 #(
    parameter int unsigned CW = 12,
    parameter int unsigned Q  = 3329
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [CW-1:0] z,
    output logic [CW-1:0] r
);
    localparam int unsigned SW = CW + 2;
    localparam logic [SW-1:0] QS = SW'(Q);

    logic [SW-1:0] sum, s1, s2;

    // Raw sum and two-step reduction.
    always_comb begin
        sum = SW'(x) + SW'(y) + SW'(z);
        s1  = (sum >= QS) ? sum - QS : sum;
        s2  = (s1  >= QS) ? s1  - QS : s1;
        r   = s2[CW-1:0];
    end
endmodule

// File: rtl/poly_msg_acc.sv
// Top: streams two banks in lockstep, adds the expanded message term,
// reduces mod Q and writes the result in place into bank A.
// Assumes msg stays stable while busy and both banks have 1-cycle reads.
module poly_msg_acc
    import poly_msg_acc_pkg::*;
#(
    parameter int unsigned N  = PMA_N,
    parameter int unsigned CW = PMA_CW,
    parameter int unsigned Q  = PMA_Q,
    parameter int unsigned AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  msg,
    output logic          busy,
    output logic          done,
    output logic          a_re,
    output logic [AW-1:0] a_raddr,
    input  logic [CW-1:0] a_rdata,
    output logic          a_we,
    output logic [AW-1:0] a_waddr,
    output logic [CW-1:0] a_wdata,
    output logic          b_re,
    output logic [AW-1:0] b_raddr,
    input  logic [CW-1:0] b_rdata
);
    logic          rd_en, wr_en;
    logic [AW-1:0] rd_idx, wr_idx;
    logic [CW-1:0] mterm;

    pma_seq #(.N(N), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_en(rd_en), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx),
        .busy(busy), .done(done)
    );

    pma_msg_term #(.N(N), .AW(AW), .CW(CW), .Q(Q)) u_msg (
        .msg(msg), .idx(wr_idx), .term(mterm)
    );

    pma_modadd3 #(.CW(CW), .Q(Q)) u_add (
        .x(a_rdata), .y(b_rdata), .z(mterm), .r(a_wdata)
    );

    // Both banks share one read address stream; writes go to bank A only.
    assign a_re    = rd_en;
    assign b_re    = rd_en;
    assign a_raddr = rd_idx;
    assign b_raddr = rd_idx;
    assign a_we    = wr_en;
    assign a_waddr = wr_idx;
endmodule

// File: rtl/pma_chk.sv
// Checker for poly_msg_acc: protocol and timing properties, bound below.
module pma_chk #(
    parameter int unsigned N  = 256,
    parameter int unsigned CW = 12,
    parameter int unsigned Q  = 3329,
    parameter int unsigned AW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          a_re,
    input logic [AW-1:0] a_raddr,
    input logic          a_we,
    input logic [AW-1:0] a_waddr,
    input logic [CW-1:0] a_wdata,
    input logic          b_re,
    input logic [AW-1:0] b_raddr
);
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!a_re && !b_re && !a_we));

    p_in_place_r4: assert property (@(posedge clk) disable iff (!rst_n)
        a_we |-> ($past(a_re) && a_waddr == $past(a_raddr)));

    p_lockstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        a_re |-> (b_re && b_raddr == a_raddr));

    p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_re && $past(a_re)) |-> (a_raddr == $past(a_raddr) + 1'b1));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(a_we) && $past(a_waddr) == LAST && !busy));

    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && a_re) |=> (a_raddr != '0));

    p_reduced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        a_we |-> (a_wdata < CW'(Q)));
endmodule

bind poly_msg_acc pma_chk #(.N(N), .CW(CW), .Q(Q), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .a_re(a_re), .a_raddr(a_raddr), .a_we(a_we), .a_waddr(a_waddr),
    .a_wdata(a_wdata), .b_re(b_re), .b_raddr(b_raddr)
);

// File: tb/sim_poly_msg_acc.sv
// Directed bench for poly_msg_acc: bank models, one task per scenario.
module sim_poly_msg_acc;
    localparam int N = 256;
    localparam int Q = 3329;
    localparam int HALFQ = 1665;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   msg = '0;
    logic           busy, done;
    logic           a_re, a_we, b_re;
    logic [7:0]     a_raddr, a_waddr, b_raddr;
    logic [11:0]    a_rdata, a_wdata, b_rdata;

    logic [11:0]    mem_a [N];
    logic [11:0]    mem_b [N];
    logic [11:0]    expv  [N];
    int             wr_log [N];
    int             wr_cnt;
    int             checks = 0;
    int             failures = 0;

    always #5 clk = ~clk;

    poly_msg_acc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .msg(msg),
        .busy(busy), .done(done),
        .a_re(a_re), .a_raddr(a_raddr), .a_rdata(a_rdata),
        .a_we(a_we), .a_waddr(a_waddr), .a_wdata(a_wdata),
        .b_re(b_re), .b_raddr(b_raddr), .b_rdata(b_rdata)
    );

    // Bank models with one-cycle read latency; bank A logs every write.
    always @(posedge clk) begin
        if (a_re) a_rdata <= mem_a[a_raddr];
        if (b_re) b_rdata <= mem_b[b_raddr];
        if (a_we) begin
            mem_a[a_waddr] <= a_wdata;
            if (wr_cnt < N) wr_log[wr_cnt] = int'(a_waddr);
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int mode);
        for (int w = 0; w < N; w++) begin
            case (mode)
                0: begin mem_a[w] = 12'(($urandom % Q)); mem_b[w] = 12'(($urandom % Q)); end
                1: begin mem_a[w] = 12'(Q - 1); mem_b[w] = 12'(Q - 1); end
                default: begin mem_a[w] = 12'd0; mem_b[w] = 12'd0; end
            endcase
            expv[w] = 12'((int'(mem_a[w]) + int'(mem_b[w]) + (msg[w] ? HALFQ : 0)) % Q);
        end
    endtask

    // Runs one pass; optionally pulses start again mid-pass. Checks timing,
    // write order and contents.
    task automatic run_pass(input string name, input bit restart);
        int cyc;
        int bad;
        wr_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy === 1'b1, "R7 busy after start", int'(busy), 1);
        cyc = 0;
        while (done !== 1'b1 && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (restart && cyc == 100) start = 1'b1;
            if (restart && cyc == 101) start = 1'b0;
        end
        chk(cyc == 257, restart ? "R8 done time with extra start" : "R7 done time", cyc, 257);
        chk(busy === 1'b0, "R7 busy low at done", int'(busy), 0);
        chk(wr_cnt == N, "R6 write count", wr_cnt, N);
        bad = 0;
        for (int w = 0; w < N; w++) if (wr_log[w] != w) bad++;
        chk(bad == 0, "R4/R6 write order in place", bad, 0);
        bad = 0;
        for (int w = 0; w < N; w++) if (mem_a[w] !== expv[w]) begin
            if (bad == 0) chk(1'b0, {"R2 ", name}, int'(mem_a[w]), int'(expv[w]));
            bad++;
        end
        chk(bad == 0, {"R2 mismatches ", name}, bad, 0);
        @(negedge clk);
        chk(done === 1'b0, "R7 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, a_re, b_re, a_we} === 5'b0, "R1 reset outputs", int'({busy, done, a_re, b_re, a_we}), 0);
    endtask

    task automatic t_random();
        msg = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        load(0);
        run_pass("random", 1'b0);
    endtask

    task automatic t_msg_only();
        msg = {128{2'b01}};
        load(2);
        run_pass("R3 message expansion", 1'b0);
        chk(mem_a[0] == 12'(HALFQ), "R3 bit0 set", int'(mem_a[0]), HALFQ);
        chk(mem_a[1] == 12'd0, "R3 bit1 clear", int'(mem_a[1]), 0);
    endtask

    task automatic t_max();
        msg = '1;
        load(1);
        run_pass("R9 max sum", 1'b0);
        chk(mem_a[7] == 12'((2 * (Q - 1) + HALFQ) % Q), "R9 max reduced", int'(mem_a[7]), (2 * (Q - 1) + HALFQ) % Q);
    endtask

    task automatic t_restart();
        msg = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        load(0);
        run_pass("R8 start while busy", 1'b1);
    endtask

    task automatic t_lockstep();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (10) @(negedge clk);
        chk(a_re && b_re && a_raddr == b_raddr, "R5 same-cycle reads", int'(b_raddr), int'(a_raddr));
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wr_cnt = 0;
        t_reset();
        t_random();
        t_random();
        t_msg_only();
        t_max();
        t_restart();
        t_lockstep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule